// File: doc/BRIEF.md
# Posted Write Queue with Burst-Room Ready

This block accepts CPU-side writes with no wait states and holds them until a downstream target drains them. Two first-in first-out stores run side by side: one keeps write addresses, each tagged with the word count of its burst, and the other keeps 32-bit data words. The master presents an address strobe and a data strobe every cycle. A push is taken whenever the store it targets has a free entry.

An active-low ready output tells the master whether it may start a new burst of up to eight words. It is not a full flag. It is a registered function of the occupancy of both stores, plus a look-ahead on a push in the current cycle. The thresholds keep enough free space for a complete eight-word burst.

On the drain side, the target sees the head address, its length code and the head data word. It pops one data word per strobe. The address entry leaves the store together with the last data word of its burst.

Top module: `wr_post_queue`

## Requirements
- R1: A synchronous active-high reset empties both stores, clears both overflow flags and the burst beat position, and drives `wr_rdy_n` low on the cycle after the reset edge.
- R2: `wr_rdy_n` is high on the cycle after a clock edge at which the address store held more than two entries, or held exactly two while an address push was accepted.
- R3: `wr_rdy_n` is high on the cycle after an edge at which the address store held two or more entries and the data store held more than four words, or held exactly four while a data push was accepted.
- R4: `wr_rdy_n` is high on the cycle after an edge at which the address store held exactly one entry and the data store held more than six words, or held exactly six while a data push was accepted.
- R5: When none of the conditions in R2 to R4 hold at an edge, `wr_rdy_n` is low on the following cycle. This covers an empty address store.
- R6: Addresses leave in the order they were pushed, and so do data words. `rd_len` carries the length code pushed with the address, where code k means a burst of k+1 words (0 to 7).
- R7: `rd_last` is high when the head data word is the final word of the head burst. The head address is removed only by a pop of that final word, and stays unchanged on earlier pops.
- R8: A pop is accepted only when both the address store and the data store are non-empty. A push into a store that is not full is accepted, and an accepted push and pop in the same cycle leave that store's occupancy unchanged. The address store holds 4 entries and the data store holds 16.
- R9: A push into a full store is dropped, leaving its contents unchanged. It sets that store's sticky overflow flag (`ovf_addr` or `ovf_data`), which stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wa_push | input | 1 | Address push strobe |
| wa_addr | input | 32 | Write address |
| wa_len | input | 3 | Burst length code (words minus one) |
| wd_push | input | 1 | Data push strobe |
| wd_data | input | 32 | Write data word |
| wr_rdy_n | output | 1 | Active-low room-for-a-burst indication |
| rd_pop | input | 1 | Drain strobe, pops one data word |
| rd_addr_vld | output | 1 | Address store non-empty |
| rd_addr | output | 32 | Head address |
| rd_len | output | 3 | Head burst length code |
| rd_data_vld | output | 1 | Data store non-empty |
| rd_data | output | 32 | Head data word |
| rd_last | output | 1 | Head data word ends the head burst |
| ovf_addr | output | 1 | Sticky address overflow |
| ovf_data | output | 1 | Sticky data overflow |

## Verification
The bench aims at the exact threshold edges. These are two addresses with a third arriving, four data words with a fifth arriving, and one address with six words and a seventh arriving. A design that ignores the same-cycle look-ahead, or uses >= where > is meant, toggles ready one cycle late or one entry early. Long stretches with the drain stalled fill both stores to overflow. A design that still writes on a full push corrupts the head data, and one with a non-sticky flag drops it on the next cycle. Random pop traffic, with data arriving after or ahead of its address, checks that the address leaves only with the final beat. It also checks that a same-cycle push and pop does not change occupancy, since either fault shifts `rd_addr`, `rd_last` or ready away from the bench model.

// File: rtl/wpq_pkg.sv
package wpq_pkg;
  localparam int unsigned ADDR_W    = 32;
  localparam int unsigned DATA_W    = 32;
  localparam int unsigned MAX_BURST = 8;
  localparam int unsigned LEN_W     = $clog2(MAX_BURST);

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [LEN_W-1:0]  len;
  } wpq_aent_t;
endpackage

// File: rtl/wpq_fifo.sv
module wpq_fifo #(
  parameter int unsigned W     = 32,
  parameter int unsigned DEPTH = 16
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         push,
  input  logic [W-1:0]                 wdata,
  input  logic                         pop,
  output logic [W-1:0]                 rdata,
  output logic [$clog2(DEPTH+1)-1:0]   count,
  output logic                         full,
  output logic                         empty,
  output logic                         push_ok,
  output logic                         ovf
);
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH+1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic          pop_ok;

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign push_ok = push & ~full;
  assign pop_ok  = pop & ~empty;

  // storage without reset so it maps to distributed RAM
  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= wdata;
  end

  assign rdata = mem[rd_ptr];

  function automatic logic [PW-1:0] ptr_inc(input logic [PW-1:0] p);
    if (p == PW'(DEPTH-1)) ptr_inc = '0;
    else                   ptr_inc = p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
      ovf    <= 1'b0;
    end else begin
      if (push_ok) wr_ptr <= ptr_inc(wr_ptr);
      if (pop_ok)  rd_ptr <= ptr_inc(rd_ptr);
      case ({push_ok, pop_ok})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
      if (push & full) ovf <= 1'b1;
    end
  end
endmodule

// File: rtl/wpq_ready.sv
module wpq_ready #(
  parameter int unsigned ACW      = 3,
  parameter int unsigned DCW      = 5,
  parameter int unsigned A_LIM    = 2,
  parameter int unsigned D_LIM_HI = 4,
  parameter int unsigned D_LIM_LO = 6
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [ACW-1:0] a_cnt,
  input  logic [DCW-1:0] d_cnt,
  input  logic           a_push_ok,
  input  logic           d_push_ok,
  output logic           rdy_n
);
  logic blk_addr, blk_two, blk_one, blk;

  always_comb begin
    blk_addr = (a_cnt > ACW'(A_LIM)) || ((a_cnt == ACW'(A_LIM)) && a_push_ok);
    blk_two  = (a_cnt >= ACW'(A_LIM)) &&
               ((d_cnt > DCW'(D_LIM_HI)) || ((d_cnt == DCW'(D_LIM_HI)) && d_push_ok));
    blk_one  = (a_cnt == ACW'(1)) &&
               ((d_cnt > DCW'(D_LIM_LO)) || ((d_cnt == DCW'(D_LIM_LO)) && d_push_ok));
    blk      = blk_addr | blk_two | blk_one;
  end

  always_ff @(posedge clk) begin
    if (rst) rdy_n <= 1'b0;
    else     rdy_n <= blk;
  end
endmodule

// File: rtl/wr_post_queue.sv
module wr_post_queue
  import wpq_pkg::*;
#(
  parameter int unsigned ADEPTH = 4,
  parameter int unsigned DDEPTH = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wa_push,
  input  logic [ADDR_W-1:0] wa_addr,
  input  logic [LEN_W-1:0]  wa_len,
  input  logic              wd_push,
  input  logic [DATA_W-1:0] wd_data,
  output logic              wr_rdy_n,
  input  logic              rd_pop,
  output logic              rd_addr_vld,
  output logic [ADDR_W-1:0] rd_addr,
  output logic [LEN_W-1:0]  rd_len,
  output logic              rd_data_vld,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_last,
  output logic              ovf_addr,
  output logic              ovf_data
);
  localparam int unsigned ACW = $clog2(ADEPTH+1);
  localparam int unsigned DCW = $clog2(DDEPTH+1);
  localparam int unsigned AEW = $bits(wpq_aent_t);

  wpq_aent_t      a_in, a_head;
  logic [AEW-1:0] a_head_raw;
  logic [ACW-1:0] a_cnt;
  logic [DCW-1:0] d_cnt;
  logic           a_full, a_empty, a_push_ok;
  logic           d_full, d_empty, d_push_ok;
  logic           pop_acc, a_pop;
  logic [LEN_W-1:0] beat;

  assign a_in.addr = wa_addr;
  assign a_in.len  = wa_len;

  wpq_fifo #(.W(AEW), .DEPTH(ADEPTH)) u_aq (
    .clk(clk), .rst(rst), .push(wa_push), .wdata(a_in), .pop(a_pop),
    .rdata(a_head_raw), .count(a_cnt), .full(a_full), .empty(a_empty),
    .push_ok(a_push_ok), .ovf(ovf_addr)
  );

  wpq_fifo #(.W(DATA_W), .DEPTH(DDEPTH)) u_dq (
    .clk(clk), .rst(rst), .push(wd_push), .wdata(wd_data), .pop(pop_acc),
    .rdata(rd_data), .count(d_cnt), .full(d_full), .empty(d_empty),
    .push_ok(d_push_ok), .ovf(ovf_data)
  );

  assign a_head = wpq_aent_t'(a_head_raw);

  // one word leaves per accepted pop; the address goes with the final word
  assign pop_acc = rd_pop & ~a_empty & ~d_empty;
  assign rd_last = (beat == a_head.len);
  assign a_pop   = pop_acc & rd_last;

  always_ff @(posedge clk) begin
    if (rst)          beat <= '0;
    else if (pop_acc) beat <= rd_last ? '0 : beat + 1'b1;
  end

  assign rd_addr_vld = ~a_empty;
  assign rd_data_vld = ~d_empty;
  assign rd_addr     = a_head.addr;
  assign rd_len      = a_head.len;

  wpq_ready #(.ACW(ACW), .DCW(DCW)) u_rdy (
    .clk(clk), .rst(rst), .a_cnt(a_cnt), .d_cnt(d_cnt),
    .a_push_ok(a_push_ok), .d_push_ok(d_push_ok), .rdy_n(wr_rdy_n)
  );

  logic unused_full;
  assign unused_full = a_full ^ d_full;
endmodule

// File: rtl/wpq_chk.sv
module wpq_chk #(
  parameter int unsigned ACW    = 3,
  parameter int unsigned DCW    = 5,
  parameter int unsigned ADEPTH = 4
) (
  input logic           clk,
  input logic           rst,
  input logic [ACW-1:0] a_cnt,
  input logic [DCW-1:0] d_cnt,
  input logic           wr_rdy_n,
  input logic           rd_pop,
  input logic           rd_addr_vld,
  input logic           rd_data_vld,
  input logic           rd_last,
  input logic [31:0]    rd_addr,
  input logic           ovf_addr,
  input logic           ovf_data
);
  a_r1_reset_ready: assert property (@(posedge clk) rst |=> !wr_rdy_n);

  a_r2_addr_block: assert property (@(posedge clk) disable iff (rst)
    (a_cnt > ACW'(2)) |=> wr_rdy_n);

  a_r4_one_addr_block: assert property (@(posedge clk) disable iff (rst)
    ((a_cnt == ACW'(1)) && (d_cnt > DCW'(6))) |=> wr_rdy_n);

  a_r7_addr_held: assert property (@(posedge clk) disable iff (rst)
    (rd_pop && rd_addr_vld && rd_data_vld && !rd_last) |=> $stable(rd_addr));

  a_r8_addr_bound: assert property (@(posedge clk) disable iff (rst)
    a_cnt <= ACW'(ADEPTH));

  a_r9_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
    (ovf_addr |=> ovf_addr) and (ovf_data |=> ovf_data));
endmodule

bind wr_post_queue wpq_chk #(.ACW(ACW), .DCW(DCW), .ADEPTH(ADEPTH)) u_chk (
  .clk(clk), .rst(rst), .a_cnt(a_cnt), .d_cnt(d_cnt), .wr_rdy_n(wr_rdy_n),
  .rd_pop(rd_pop), .rd_addr_vld(rd_addr_vld), .rd_data_vld(rd_data_vld),
  .rd_last(rd_last), .rd_addr(rd_addr), .ovf_addr(ovf_addr), .ovf_data(ovf_data)
);

// File: tb/sim_wr_post_queue.sv
`timescale 1ns/1ps
module sim_wr_post_queue;
  logic clk = 1'b0;
  logic rst;
  logic wa_push, wd_push, rd_pop;
  logic [31:0] wa_addr, wd_data;
  logic [2:0]  wa_len;
  logic wr_rdy_n, rd_addr_vld, rd_data_vld, rd_last, ovf_addr, ovf_data;
  logic [31:0] rd_addr, rd_data;
  logic [2:0]  rd_len;

  always #4 clk = ~clk;

  wr_post_queue u0 (
    .clk(clk), .rst(rst), .wa_push(wa_push), .wa_addr(wa_addr), .wa_len(wa_len),
    .wd_push(wd_push), .wd_data(wd_data), .wr_rdy_n(wr_rdy_n), .rd_pop(rd_pop),
    .rd_addr_vld(rd_addr_vld), .rd_addr(rd_addr), .rd_len(rd_len),
    .rd_data_vld(rd_data_vld), .rd_data(rd_data), .rd_last(rd_last),
    .ovf_addr(ovf_addr), .ovf_data(ovf_data)
  );

  int n_cmp = 0, n_bad = 0;
  logic [34:0] mqa[$];
  logic [31:0] mqd[$];
  int  beat = 0;
  logic exp_rdy_n = 1'b0, m_ovfa = 1'b0, m_ovfd = 1'b0;
  string rdy_tag = "R5";
  bit done = 0;

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // ready rule from the requirements, also reports which rule applies
  function automatic logic blk_rule(input int ac, input int dc, input bit ap, input bit dp, output string tag);
    tag = "R5";
    if (ac > 2 || (ac == 2 && ap)) begin tag = "R2"; return 1'b1; end
    if (ac >= 2 && (dc > 4 || (dc == 4 && dp))) begin tag = "R3"; return 1'b1; end
    if (ac == 1 && (dc > 6 || (dc == 6 && dp))) begin tag = "R4"; return 1'b1; end
    return 1'b0;
  endfunction

  task automatic check_outputs(input string rtag);
    chk(rtag, "wr_rdy_n", {31'd0, wr_rdy_n}, {31'd0, exp_rdy_n});
    chk("R8", "rd_addr_vld", {31'd0, rd_addr_vld}, {31'd0, mqa.size() > 0});
    chk("R8", "rd_data_vld", {31'd0, rd_data_vld}, {31'd0, mqd.size() > 0});
    if (mqa.size() > 0) begin
      chk("R6", "rd_addr", rd_addr, mqa[0][34:3]);
      chk("R6", "rd_len", {29'd0, rd_len}, {29'd0, mqa[0][2:0]});
      chk("R7", "rd_last", {31'd0, rd_last}, {31'd0, beat == int'(mqa[0][2:0])});
    end
    if (mqd.size() > 0) chk("R6", "rd_data", rd_data, mqd[0]);
    chk("R9", "ovf_addr", {31'd0, ovf_addr}, {31'd0, m_ovfa});
    chk("R9", "ovf_data", {31'd0, ovf_data}, {31'd0, m_ovfd});
  endtask

  // drive one cycle's inputs and advance the model to the state after the edge
  task automatic cycle(input bit ap, input logic [31:0] ad, input logic [2:0] al,
                       input bit dp, input logic [31:0] dd, input bit pp);
    bit apok, dpok, pok;
    int ac, dc;
    wa_push = ap; wa_addr = ad; wa_len = al;
    wd_push = dp; wd_data = dd; rd_pop = pp;
    ac = mqa.size(); dc = mqd.size();
    apok = ap && ac < 4;
    dpok = dp && dc < 16;
    pok  = pp && ac > 0 && dc > 0;
    exp_rdy_n = blk_rule(ac, dc, apok, dpok, rdy_tag);
    if (ap && !apok) m_ovfa = 1'b1;
    if (dp && !dpok) m_ovfd = 1'b1;
    if (pok) begin
      void'(mqd.pop_front());
      if (beat == int'(mqa[0][2:0])) begin void'(mqa.pop_front()); beat = 0; end
      else beat++;
    end
    if (apok) mqa.push_back({ad, al});
    if (dpok) mqd.push_back(dd);
    @(negedge clk);
    check_outputs(rdy_tag);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    wa_push = 0; wd_push = 0; rd_pop = 0; wa_addr = 0; wd_data = 0; wa_len = 0;
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
    mqa.delete(); mqd.delete(); beat = 0;
    m_ovfa = 0; m_ovfd = 0; exp_rdy_n = 0;
    check_outputs("R1");
  endtask

  initial begin
    void'($urandom(32'd1234));
    @(negedge clk);
    do_reset();
    // directed: two addresses then a third pushed -> R2 look-ahead
    cycle(1, 32'h100, 3'd0, 0, 0, 0);
    cycle(1, 32'h200, 3'd1, 0, 0, 0);
    cycle(1, 32'h300, 3'd7, 0, 0, 0);   // ac=2 with push -> high next
    cycle(0, 0, 0, 0, 0, 0);
    // pop data so address count drops: feed data words
    for (int i = 0; i < 6; i++) cycle(0, 0, 0, 1, 32'hA000 + i, 0);
    // R3 / drain; R7 addr leaves only with final beat
    for (int i = 0; i < 8; i++) cycle(0, 0, 0, 0, 0, 1);
    // fill to overflow both stores (R9)
    for (int i = 0; i < 6; i++) cycle(1, 32'h400 + i, 3'd7, 0, 0, 0);
    for (int i = 0; i < 20; i++) cycle(0, 0, 0, 1, 32'hB000 + i, 0);
    for (int i = 0; i < 40; i++) cycle(0, 0, 0, 0, 0, 1);
    do_reset();
    // directed R4: one address, six words then a seventh
    cycle(1, 32'h500, 3'd7, 0, 0, 0);
    for (int i = 0; i < 8; i++) cycle(0, 0, 0, 1, 32'hC000 + i, 0);
    for (int i = 0; i < 8; i++) cycle(0, 0, 0, 0, 0, 1);
    // random phases
    for (int i = 0; i < 6000; i++) begin
      int pp_pct;
      bit ap, dp, pp;
      pp_pct = ((i / 300) % 2 == 0) ? 70 : 15;
      ap = ($urandom % 100) < 20;
      dp = ($urandom % 100) < 45;
      pp = ($urandom % 100) < pp_pct;
      cycle(ap, $urandom, 3'($urandom % 8), dp, $urandom, pp);
      if (i == 3000) do_reset();
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired R1 actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule